// File: doc/BRIEF.md
# Cache-Block Maintenance Permission Resolver

This block decides what happens to one cache-block maintenance request (clean, flush or invalidate) before any cache is touched. It takes a base address and a block-size exponent and forms the block-aligned address by clearing the low exponent bits. It then combines the address translation outcome with the separate read and write permission results for the physical block.

The result is either a plain success or exactly one trap. A trap carries a store-class cause code, and its faulting address is the aligned address. Access is granted when either the read or the write check passes; instruction-fetch permission plays no part. Every denial is reported in its store form, even when a load-type check raised it. A fault type that cannot occur on this path is flagged as an internal error and does not raise a trap. The block does not perform the cache maintenance itself, and it does not walk page tables.

The controller is a small state machine. `ST_IDLE` waits for `req_valid` and captures every input. The `go_resolve` transition leads to `ST_RESOLVE`, which computes the aligned address and the decision. From there, one of three transitions is taken: `to_grant` to `ST_GRANT`, `to_trap` to `ST_TRAP`, or `to_interr` to `ST_INTERR`. Each of those outcome states lasts one cycle, raises `done`, and returns to `ST_IDLE` through `back_idle`.

Top module: `cbo_perm_mapper`

## Requirements
- R1: `blk_addr` equals `req_base` with bits below `req_exp` forced to zero; an exponent of 0 leaves the address unchanged.
- R2: A request accepted at clock edge k produces a one-cycle `done` pulse that is high between edge k+1 and edge k+2, and low otherwise.
- R3: `req_valid` is ignored while a request is in progress, which is the two cycles after acceptance. Such a request produces no extra `done` pulse and does not change the result.
- R4: When `xl_ok` is 0, the outcome is determined by `xl_kind` alone, whatever `rd_ok`, `wr_ok` and `wr_kind` are.
- R5: When `xl_ok` is 1 and at least one of `rd_ok` or `wr_ok` is 1, the request completes with `exc_valid`=0, `int_err`=0 and `exc_cause`=0.
- R6: When `xl_ok` is 1 and both `rd_ok` and `wr_ok` are 0, the outcome is determined by `wr_kind`.
- R7: Fault kinds are 3-bit codes: 0 = load access, 1 = store access, 2 = load page, 3 = store page. Codes 0 and 1 give `exc_cause`=7, and codes 2 and 3 give `exc_cause`=15, with `exc_valid`=1.
- R8: Fault kind codes 4 to 7 give `int_err`=1 together with `done`, and `exc_valid`=0 and `exc_cause`=0.
- R9: `fault_addr` equals `blk_addr` while `exc_valid` is 1, and is 0 at all other times.
- R10: After reset, `done`, `exc_valid` and `int_err` are 0, and `blk_addr`, `exc_cause` and `fault_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, accepted in idle |
| req_base | input | ADDR_W | Base virtual address |
| req_exp | input | EXP_W | Block-size exponent |
| xl_ok | input | 1 | Translation succeeded |
| xl_kind | input | 3 | Translation fault kind |
| rd_ok | input | 1 | Physical read check passed |
| wr_ok | input | 1 | Physical write check passed |
| wr_kind | input | 3 | Physical write check fault kind |
| blk_addr | output | ADDR_W | Block-aligned address of the last request |
| done | output | 1 | Completion pulse |
| exc_valid | output | 1 | Trap raised |
| exc_cause | output | 5 | Trap cause code |
| fault_addr | output | ADDR_W | Faulting address on a trap |
| int_err | output | 1 | Impossible fault kind seen |

## Verification
The bench covers every exponent against every base in a narrow address configuration, so an off-by-one in the alignment mask shows up at exponent 0 and at the largest exponent. It then sweeps every combination of translation status, both permission bits and both fault-kind fields. Three kinds of error are exposed by this sweep: a design that requires both permissions, one that lets a translation fault be overridden by the physical checks, and one that reports load causes 5 or 13. A request raised during the busy cycles checks that a second pulse never appears and that the first result is not corrupted.

// File: rtl/cbpm_pkg.sv
package cbpm_pkg;

    localparam int KIND_W  = 3;
    localparam int CAUSE_W = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_ST_ACCESS = 5'd7;
    localparam logic [CAUSE_W-1:0] CAUSE_ST_PAGE   = 5'd15;

    typedef enum logic [KIND_W-1:0] {
        FK_LD_ACCESS = 3'd0,
        FK_ST_ACCESS = 3'd1,
        FK_LD_PAGE   = 3'd2,
        FK_ST_PAGE   = 3'd3,
        FK_IF_ACCESS = 3'd4,
        FK_IF_PAGE   = 3'd5,
        FK_MISALIGN  = 3'd6,
        FK_RESERVED  = 3'd7
    } fault_kind_e;

    typedef enum logic [1:0] {
        OC_GRANT  = 2'd0,
        OC_TRAP   = 2'd1,
        OC_INTERR = 2'd2
    } outcome_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_RESOLVE = 3'd1,
        ST_GRANT   = 3'd2,
        ST_TRAP    = 3'd3,
        ST_INTERR  = 3'd4
    } state_e;

endpackage

// File: rtl/cbpm_align.sv
module cbpm_align #(
    parameter int ADDR_W = 64,
    parameter int EXP_W  = 6
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [EXP_W-1:0]  expo,
    output logic [ADDR_W-1:0] aligned
);
    localparam int CMP_W = EXP_W + 1;

    logic [CMP_W-1:0] expo_ext;
    assign expo_ext = {1'b0, expo};

    for (genvar gi = 0; gi < ADDR_W; gi++) begin : g_bit
        localparam logic [CMP_W-1:0] BIT_IDX = CMP_W'(gi);
        assign aligned[gi] = (BIT_IDX >= expo_ext) ? base[gi] : 1'b0;
    end

endmodule

// File: rtl/cbpm_fault_map.sv
module cbpm_fault_map
    import cbpm_pkg::*;
(
    input  logic [KIND_W-1:0]  kind,
    output logic [CAUSE_W-1:0] cause,
    output logic               known
);
    always_comb begin
        cause = '0;
        known = 1'b1;
        unique case (kind)
            FK_LD_ACCESS, FK_ST_ACCESS: cause = CAUSE_ST_ACCESS;
            FK_LD_PAGE,   FK_ST_PAGE:   cause = CAUSE_ST_PAGE;
            default:                    known = 1'b0;
        endcase
    end

    always_comb begin
        if (known) begin
            AST_KNOWN_IS_STORE: assert (cause == CAUSE_ST_ACCESS || cause == CAUSE_ST_PAGE); // R7
        end
    end

endmodule

// File: rtl/cbpm_resolve.sv
module cbpm_resolve
    import cbpm_pkg::*;
(
    input  logic               xl_ok,
    input  logic [KIND_W-1:0]  xl_kind,
    input  logic               rd_ok,
    input  logic               wr_ok,
    input  logic [KIND_W-1:0]  wr_kind,
    output outcome_e           outcome,
    output logic [CAUSE_W-1:0] cause
);
    logic [KIND_W-1:0]  sel_kind;
    logic [CAUSE_W-1:0] map_cause;
    logic               map_known;
    logic               any_perm;

    assign any_perm = rd_ok | wr_ok;
    assign sel_kind = xl_ok ? wr_kind : xl_kind;

    cbpm_fault_map i_map (
        .kind  (sel_kind),
        .cause (map_cause),
        .known (map_known)
    );

    always_comb begin
        outcome = OC_GRANT;
        cause   = '0;
        if (xl_ok && any_perm) begin
            outcome = OC_GRANT;
        end else if (map_known) begin
            outcome = OC_TRAP;
            cause   = map_cause;
        end else begin
            outcome = OC_INTERR;
        end
    end

endmodule

// File: rtl/cbo_perm_mapper.sv
module cbo_perm_mapper
    import cbpm_pkg::*;
#(
    parameter int ADDR_W = 64,
    parameter int EXP_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [EXP_W-1:0]  req_exp,
    input  logic              xl_ok,
    input  logic [2:0]        xl_kind,
    input  logic              rd_ok,
    input  logic              wr_ok,
    input  logic [2:0]        wr_kind,
    output logic [ADDR_W-1:0] blk_addr,
    output logic              done,
    output logic              exc_valid,
    output logic [4:0]        exc_cause,
    output logic [ADDR_W-1:0] fault_addr,
    output logic              int_err
);
    state_e state_q, state_d;

    logic [ADDR_W-1:0]  cap_base;
    logic [EXP_W-1:0]   cap_exp;
    logic               cap_xl_ok;
    logic [KIND_W-1:0]  cap_xl_kind;
    logic               cap_rd_ok;
    logic               cap_wr_ok;
    logic [KIND_W-1:0]  cap_wr_kind;

    logic [ADDR_W-1:0]  blk_q;
    logic [CAUSE_W-1:0] cause_q;

    logic [ADDR_W-1:0]  aligned_c;
    outcome_e           outcome_c;
    logic [CAUSE_W-1:0] cause_c;

    cbpm_align #(.ADDR_W(ADDR_W), .EXP_W(EXP_W)) i_align (
        .base    (cap_base),
        .expo    (cap_exp),
        .aligned (aligned_c)
    );

    cbpm_resolve i_resolve (
        .xl_ok   (cap_xl_ok),
        .xl_kind (cap_xl_kind),
        .rd_ok   (cap_rd_ok),
        .wr_ok   (cap_wr_ok),
        .wr_kind (cap_wr_kind),
        .outcome (outcome_c),
        .cause   (cause_c)
    );

    // next-state logic: go_resolve, to_grant, to_trap, to_interr, back_idle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_RESOLVE;
            ST_RESOLVE: begin
                unique case (outcome_c)
                    OC_GRANT:  state_d = ST_GRANT;
                    OC_TRAP:   state_d = ST_TRAP;
                    default:   state_d = ST_INTERR;
                endcase
            end
            ST_GRANT, ST_TRAP, ST_INTERR: state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            cap_base    <= '0;
            cap_exp     <= '0;
            cap_xl_ok   <= 1'b0;
            cap_xl_kind <= '0;
            cap_rd_ok   <= 1'b0;
            cap_wr_ok   <= 1'b0;
            cap_wr_kind <= '0;
            blk_q       <= '0;
            cause_q     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && req_valid) begin
                cap_base    <= req_base;
                cap_exp     <= req_exp;
                cap_xl_ok   <= xl_ok;
                cap_xl_kind <= xl_kind;
                cap_rd_ok   <= rd_ok;
                cap_wr_ok   <= wr_ok;
                cap_wr_kind <= wr_kind;
            end
            if (state_q == ST_RESOLVE) begin
                blk_q   <= aligned_c;
                cause_q <= cause_c;
            end
        end
    end

    // output logic
    always_comb begin
        done       = 1'b0;
        exc_valid  = 1'b0;
        exc_cause  = '0;
        fault_addr = '0;
        int_err    = 1'b0;
        unique case (state_q)
            ST_GRANT:  done = 1'b1;
            ST_TRAP: begin
                done       = 1'b1;
                exc_valid  = 1'b1;
                exc_cause  = cause_q;
                fault_addr = blk_q;
            end
            ST_INTERR: begin
                done    = 1'b1;
                int_err = 1'b1;
            end
            default: ;
        endcase
    end

    assign blk_addr = blk_q;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R2
    AST_ACCEPT_TO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && req_valid) |=> ##1 done); // R2
    AST_BUSY_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE) |=> (state_q != ST_RESOLVE)); // R3
    AST_GRANT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESOLVE && cap_xl_ok && (cap_rd_ok || cap_wr_ok))
        |=> (done && !exc_valid && !int_err)); // R5
    AST_TRAP_STORE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_cause == 5'd7 || exc_cause == 5'd15)); // R7
    AST_TRAP_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_valid && int_err)); // R8
    AST_FAULT_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (fault_addr == blk_addr)); // R9
    AST_ALIGN_LOW_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((blk_addr & ~({ADDR_W{1'b1}} << cap_exp)) == '0)); // R1

endmodule

// File: tb/test_cbo_perm_mapper.sv
module test_cbo_perm_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int EW = 3;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_base = '0;
    logic [EW-1:0] req_exp = '0;
    logic          xl_ok = 1'b0;
    logic [2:0]    xl_kind = '0;
    logic          rd_ok = 1'b0;
    logic          wr_ok = 1'b0;
    logic [2:0]    wr_kind = '0;
    logic [AW-1:0] blk_addr;
    logic          done;
    logic          exc_valid;
    logic [4:0]    exc_cause;
    logic [AW-1:0] fault_addr;
    logic          int_err;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbo_perm_mapper #(.ADDR_W(AW), .EXP_W(EW)) i_cbo_perm_mapper (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_base(req_base),
        .req_exp(req_exp), .xl_ok(xl_ok), .xl_kind(xl_kind), .rd_ok(rd_ok),
        .wr_ok(wr_ok), .wr_kind(wr_kind), .blk_addr(blk_addr), .done(done),
        .exc_valid(exc_valid), .exc_cause(exc_cause), .fault_addr(fault_addr),
        .int_err(int_err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // expected outcome: 0 grant, 1 trap, 2 internal error
    task automatic expect_of(input bit xo, input int xk, input bit r, input bit w,
                             input int wk, output int oc, output int cause);
        int k;
        if (xo && (r || w)) begin
            oc = 0; cause = 0;
        end else begin
            k = xo ? wk : xk;
            if (k <= 1)      begin oc = 1; cause = 7;  end
            else if (k <= 3) begin oc = 1; cause = 15; end
            else             begin oc = 2; cause = 0;  end
        end
    endtask

    task automatic run_op(input int base, input int ex, input bit xo, input int xk,
                          input bit r, input bit w, input int wk, input bit poke_busy,
                          input string tag);
        int oc, cause, exp_addr;
        expect_of(xo, xk, r, w, wk, oc, cause);
        exp_addr = base & ~((1 << ex) - 1) & ((1 << AW) - 1);
        @(negedge clk);
        req_valid = 1'b1;
        req_base = AW'(base); req_exp = EW'(ex);
        xl_ok = xo; xl_kind = 3'(xk); rd_ok = r; wr_ok = w; wr_kind = 3'(wk);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, "R2 done low while resolving", int'(done), 0);
        if (poke_busy) begin
            req_base = ~AW'(base); req_exp = '0;
            xl_ok = 1'b1; rd_ok = 1'b1; wr_ok = 1'b1;
        end else begin
            req_valid = 1'b0;
        end
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b1, {tag, " R2 done pulse"}, int'(done), 1);
        chk(int'(blk_addr) == exp_addr, {tag, " R1 aligned address"}, int'(blk_addr), exp_addr);
        chk(exc_valid == (oc == 1), {tag, " exc_valid"}, int'(exc_valid), int'(oc == 1));
        chk(int'(exc_cause) == cause, {tag, " R7 cause"}, int'(exc_cause), cause);
        chk(int_err == (oc == 2), {tag, " R8 int_err"}, int'(int_err), int'(oc == 2));
        chk(int'(fault_addr) == ((oc == 1) ? exp_addr : 0), {tag, " R9 fault_addr"},
            int'(fault_addr), (oc == 1) ? exp_addr : 0);
        req_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R3 no extra done"}, int'(done), 0);
        @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0, {tag, " R3 still idle"}, int'(done), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(done == 1'b0 && exc_valid == 1'b0 && int_err == 1'b0, "R10 reset flags",
            int'({done, exc_valid, int_err}), 0);
        chk(blk_addr == '0 && exc_cause == '0 && fault_addr == '0, "R10 reset values",
            int'(blk_addr) + int'(exc_cause) + int'(fault_addr), 0);
        rst_n = 1'b1;

        // R1: every exponent against every base, grant path
        for (int e = 0; e < (1 << EW); e++) begin
            for (int b = 0; b < (1 << AW); b++) begin
                run_op(b, e, 1'b1, 0, 1'b1, 1'b0, 0, 1'b0, "R1 sweep");
            end
        end

        // R4 R5 R6 R7 R8: full decision sweep
        for (int xo = 0; xo < 2; xo++) begin
            for (int xk = 0; xk < 8; xk++) begin
                for (int r = 0; r < 2; r++) begin
                    for (int w = 0; w < 2; w++) begin
                        for (int wk = 0; wk < 8; wk++) begin
                            run_op(8'hB7, 3, xo[0], xk, r[0], w[0], wk, 1'b0,
                                   xo ? ((r || w) ? "R5 grant" : "R6 write kind")
                                      : "R4 xlate fault");
                        end
                    end
                end
            end
        end

        // R3: request held high during the busy cycle is ignored
        run_op(8'h5D, 2, 1'b1, 0, 1'b0, 1'b0, 2, 1'b1, "R3 busy trap");
        run_op(8'hFF, 7, 1'b0, 1, 1'b1, 1'b1, 0, 1'b1, "R3 busy xlate");
        run_op(8'h3C, 0, 1'b1, 0, 1'b0, 1'b0, 6, 1'b1, "R3 busy interr");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule